// File: doc/BRIEF.md
# Paged Address Translation Unit

This block maps 16-bit logical addresses onto 24-bit physical addresses through a page table kept in on-chip storage. A logical address is split into an 8-bit page number and an 8-bit byte offset, so each page is 256 bytes. The page number selects one of 256 table entries. Each entry holds a 16-bit frame field and three status bits: present, accessed and dirty. The physical address is the frame joined to the unchanged offset.

Software fills the table through a write port that sets all four fields of one entry at once. It programs a page-limit register that holds the highest page number the current process may use. A readback port returns any entry's contents one cycle after its index is presented. A requester issues an access as a logical address plus a write flag. One cycle later the block returns a strobe with either a physical address or a trap code. The code tells apart two cases: a page beyond the limit (a protection violation) and a page within the limit whose entry is not resident (a page fault). On every access that does not trap, the block sets the entry's accessed bit, and for a write also its dirty bit. Software uses these bits to choose and clean victim pages.

When a page is not resident, its frame field may hold a location on the backing store. The block never lets that value reach the physical address output.

Top module: `pat_xlate_unit`

## Requirements
- R1: For an access that does not trap, `rsp_paddr` equals the entry's 16-bit frame in bits 23:8, followed by the offset bits 7:0 of the logical address. The entry is selected by the page number, bits 15:8 of the logical address. For example, frame 0x01A0 at page 0x02 turns logical 0x02FE into physical 0x01A0FE.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. `rsp_trap` is then 2'b00 for no trap, 2'b01 for a violation and 2'b10 for a page fault. The value 2'b11 never appears.
- R3: A page number strictly greater than the page limit yields code 2'b01 and `rsp_paddr` of zero. A page number equal to the limit is in range.
- R4: A page number within the limit whose entry has present = 0 yields code 2'b10 and `rsp_paddr` of zero, whatever the entry's frame field holds.
- R5: An access that does not trap, read or write, sets that entry's accessed bit.
- R6: A write access that does not trap sets the entry's dirty bit. A read access leaves it unchanged. Once set, the bit stays set until a table write clears it.
- R7: An access that traps leaves the accessed and dirty bits of every entry unchanged.
- R8: A table write replaces the frame, present, dirty and accessed fields of the chosen entry together. The readback port shows an entry's fields one cycle after its index is applied.
- R9: When a table write and an access hit the same entry in the same cycle, the entry afterwards holds exactly the written values. The response to that access is formed from the contents the entry had before the write. A page-limit write in the same cycle as an access likewise takes effect from the next access onward.
- R10: After reset, every entry has present, dirty and accessed at zero, the page limit is zero, and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tw_en | input | 1 | Table write enable |
| tw_idx | input | 8 | Entry written |
| tw_frame | input | 16 | Frame or backing-store location to store |
| tw_present | input | 1 | Present bit to store |
| tw_dirty | input | 1 | Dirty bit to store |
| tw_acc | input | 1 | Accessed bit to store |
| lim_we | input | 1 | Page-limit write enable |
| lim_val | input | 8 | New highest permitted page number |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 16 | Logical address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Translation result strobe |
| rsp_paddr | output | 24 | Physical address, zero on a trap |
| rsp_trap | output | 2 | 00 none, 01 violation, 10 page fault |
| rb_idx | input | 8 | Entry to read back |
| rb_frame | output | 16 | Frame field of the entry read back |
| rb_present | output | 1 | Present bit of the entry read back |
| rb_dirty | output | 1 | Dirty bit of the entry read back |
| rb_acc | output | 1 | Accessed bit of the entry read back |

## Verification
Each access is answered one cycle later. The driver computes the expected physical address and trap code from its own model of the table when it raises the request, and pushes them into a queue. A monitor pops one item at each falling edge where `rsp_valid` is high, so responses are matched in issue order. Status bits appear on the readback port one cycle after the index is applied, which lets every status change from an access be seen by the time the next readback completes. The readback task samples at the falling edge that follows the registering edge. The same-cycle write and access case is driven in a single cycle. It checks both the response, which comes from the old contents, and a later readback, which shows the written values.

// File: rtl/pat_pkg.sv
package pat_pkg;

  typedef enum logic [1:0] {
    TRAP_NONE  = 2'b00,
    TRAP_VIOL  = 2'b01,
    TRAP_FAULT = 2'b10
  } trap_e;

endpackage

// File: rtl/pat_frame_store.sv
// Frame field storage: one write port, two registered read ports.
// Reads return the contents held before a same-cycle write.
module pat_frame_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end

endmodule

// File: rtl/pat_status.sv
// Per-entry present, dirty and accessed bits with hardware update on hits.
module pat_status #(
  parameter int ENTRIES = 256,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic          wpres,
  input  logic          wdirty,
  input  logic          wacc,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic          upd_wr,
  input  logic [IW-1:0] look_idx,
  output logic          look_pres,
  input  logic [IW-1:0] rb_idx,
  output logic          rb_pres,
  output logic          rb_dirty,
  output logic          rb_acc
);

  logic [ENTRIES-1:0] pres_v;
  logic [ENTRIES-1:0] dirty_v;
  logic [ENTRIES-1:0] acc_v;

  assign look_pres = pres_v[look_idx];

  // Hit update first, table write last: the write wins on the same entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      pres_v  <= '0;
      dirty_v <= '0;
      acc_v   <= '0;
    end else begin
      if (upd_en) begin
        acc_v[upd_idx] <= 1'b1;
        if (upd_wr) dirty_v[upd_idx] <= 1'b1;
      end
      if (we) begin
        pres_v[widx]  <= wpres;
        dirty_v[widx] <= wdirty;
        acc_v[widx]   <= wacc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_pres  <= 1'b0;
      rb_dirty <= 1'b0;
      rb_acc   <= 1'b0;
    end else begin
      rb_pres  <= pres_v[rb_idx];
      rb_dirty <= dirty_v[rb_idx];
      rb_acc   <= acc_v[rb_idx];
    end
  end

endmodule

// File: rtl/pat_classify.sv
// Range check first, residency second.
module pat_classify #(
  parameter int PG_W = 8
) (
  input  logic [PG_W-1:0] page,
  input  logic [PG_W-1:0] limit,
  input  logic            present,
  output pat_pkg::trap_e  trap
);
  import pat_pkg::*;

  always_comb begin
    if (page > limit)  trap = TRAP_VIOL;
    else if (!present) trap = TRAP_FAULT;
    else               trap = TRAP_NONE;
  end

endmodule

// File: rtl/pat_xlate_unit.sv
module pat_xlate_unit #(
  parameter int LA_W    = 16,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 16,
  localparam int PG_W    = LA_W - OFF_W,
  localparam int ENTRIES = 1 << PG_W,
  localparam int PA_W    = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tw_en,
  input  logic [PG_W-1:0]    tw_idx,
  input  logic [FRAME_W-1:0] tw_frame,
  input  logic               tw_present,
  input  logic               tw_dirty,
  input  logic               tw_acc,
  input  logic               lim_we,
  input  logic [PG_W-1:0]    lim_val,
  input  logic               req_valid,
  input  logic [LA_W-1:0]    req_addr,
  input  logic               req_write,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [1:0]         rsp_trap,
  input  logic [PG_W-1:0]    rb_idx,
  output logic [FRAME_W-1:0] rb_frame,
  output logic               rb_present,
  output logic               rb_dirty,
  output logic               rb_acc
);
  import pat_pkg::*;

  logic [PG_W-1:0]    page_c;
  logic [PG_W-1:0]    limit_q;
  logic               pres_c;
  trap_e              trap_c;
  logic               hit_c;
  logic               valid_q;
  trap_e              trap_q;
  logic [OFF_W-1:0]   off_q;
  logic [FRAME_W-1:0] frame_q;

  assign page_c = req_addr[LA_W-1:OFF_W];
  assign hit_c  = req_valid && (trap_c == TRAP_NONE);

  always_ff @(posedge clk) begin
    if (rst)         limit_q <= '0;
    else if (lim_we) limit_q <= lim_val;
  end

  pat_frame_store #(.DEPTH(ENTRIES), .DW(FRAME_W)) u_frames (
    .clk     (clk),
    .we      (tw_en),
    .waddr   (tw_idx),
    .wdata   (tw_frame),
    .ra_addr (page_c),
    .ra_data (frame_q),
    .rb_addr (rb_idx),
    .rb_data (rb_frame)
  );

  pat_status #(.ENTRIES(ENTRIES)) u_status (
    .clk       (clk),
    .rst       (rst),
    .we        (tw_en),
    .widx      (tw_idx),
    .wpres     (tw_present),
    .wdirty    (tw_dirty),
    .wacc      (tw_acc),
    .upd_en    (hit_c),
    .upd_idx   (page_c),
    .upd_wr    (req_write),
    .look_idx  (page_c),
    .look_pres (pres_c),
    .rb_idx    (rb_idx),
    .rb_pres   (rb_present),
    .rb_dirty  (rb_dirty),
    .rb_acc    (rb_acc)
  );

  pat_classify #(.PG_W(PG_W)) u_class (
    .page    (page_c),
    .limit   (limit_q),
    .present (pres_c),
    .trap    (trap_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      trap_q  <= TRAP_NONE;
      off_q   <= '0;
    end else begin
      valid_q <= req_valid;
      trap_q  <= req_valid ? trap_c : TRAP_NONE;
      off_q   <= req_addr[OFF_W-1:0];
    end
  end

  // A trapped response never carries the stored frame field.
  assign rsp_valid = valid_q;
  assign rsp_trap  = trap_q;
  assign rsp_paddr = (valid_q && trap_q == TRAP_NONE) ? {frame_q, off_q} : '0;

endmodule

// File: rtl/pat_xlate_chk.sv
module pat_xlate_chk #(
  parameter int LA_W  = 16,
  parameter int OFF_W = 8,
  parameter int PA_W  = 24,
  localparam int PG_W = LA_W - OFF_W
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [LA_W-1:0] req_addr,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_trap,
  input logic [PG_W-1:0] limit_q
);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (rsp_valid == $past(req_valid)));

  // R2
  trap_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_trap != 2'b11);

  // R3
  viol_over_limit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(req_valid) &&
     ($past(req_addr[LA_W-1:OFF_W]) > $past(limit_q))) |-> (rsp_trap == 2'b01));

  // R4
  trap_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_trap != 2'b00) |-> (rsp_paddr == '0));

  // R1
  offset_kept_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && rsp_valid && rsp_trap == 2'b00) |->
      (rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0])));

endmodule

bind pat_xlate_unit pat_xlate_chk #(.LA_W(LA_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_trap  (rsp_trap),
  .limit_q   (limit_q)
);

// File: tb/sim_pat_xlate_unit.sv
module sim_pat_xlate_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ENT = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tw_en = 1'b0;
  logic [7:0]  tw_idx = '0;
  logic [15:0] tw_frame = '0;
  logic        tw_present = 1'b0, tw_dirty = 1'b0, tw_acc = 1'b0;
  logic        lim_we = 1'b0;
  logic [7:0]  lim_val = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [23:0] rsp_paddr;
  logic [1:0]  rsp_trap;
  logic [7:0]  rb_idx = '0;
  logic [15:0] rb_frame;
  logic        rb_present, rb_dirty, rb_acc;

  always #(CLK_PERIOD/2) clk = ~clk;

  pat_xlate_unit u0 (
    .clk(clk), .rst(rst),
    .tw_en(tw_en), .tw_idx(tw_idx), .tw_frame(tw_frame),
    .tw_present(tw_present), .tw_dirty(tw_dirty), .tw_acc(tw_acc),
    .lim_we(lim_we), .lim_val(lim_val),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_trap(rsp_trap),
    .rb_idx(rb_idx), .rb_frame(rb_frame), .rb_present(rb_present),
    .rb_dirty(rb_dirty), .rb_acc(rb_acc)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the table
  logic [15:0] m_frame [ENT];
  logic        m_pres [ENT];
  logic        m_dirty [ENT];
  logic        m_acc [ENT];
  logic [7:0]  m_limit;

  logic [25:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < ENT; i++) begin
      m_frame[i] = '0; m_pres[i] = 1'b0; m_dirty[i] = 1'b0; m_acc[i] = 1'b0;
    end
    m_limit = '0;
  endtask

  // Expected {trap, paddr}, and status update in the model on a hit.
  function automatic logic [25:0] predict(input logic [15:0] a, input logic wr);
    logic [7:0] pg;
    pg = a[15:8];
    if (pg > m_limit) return {2'b01, 24'h0};
    if (!m_pres[pg])  return {2'b10, 24'h0};
    m_acc[pg] = 1'b1;
    if (wr) m_dirty[pg] = 1'b1;
    return {2'b00, m_frame[pg], a[7:0]};
  endfunction

  task automatic set_req(input logic [15:0] a, input logic wr, input string tag);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    exp_q.push_back(predict(a, wr));
    tag_q.push_back(tag);
  endtask

  task automatic access(input logic [15:0] a, input logic wr, input string tag);
    set_req(a, wr, tag);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic set_tw(input logic [7:0] i, input logic [15:0] f, input logic p, input logic d, input logic ac);
    tw_en = 1'b1; tw_idx = i; tw_frame = f; tw_present = p; tw_dirty = d; tw_acc = ac;
    m_frame[i] = f; m_pres[i] = p; m_dirty[i] = d; m_acc[i] = ac;
  endtask

  task automatic twrite(input logic [7:0] i, input logic [15:0] f, input logic p, input logic d, input logic ac);
    set_tw(i, f, p, d, ac);
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic set_limit(input logic [7:0] l);
    lim_we = 1'b1; lim_val = l; m_limit = l;
    @(negedge clk);
    lim_we = 1'b0;
  endtask

  // Readback compared against the bench model.
  task automatic readback(input logic [7:0] i, input bit cmp_frame, input string tag);
    rb_idx = i;
    @(negedge clk);
    check(rb_present == m_pres[i], {tag, " present"}, 32'(rb_present), 32'(m_pres[i]));
    check(rb_dirty == m_dirty[i],  {tag, " dirty"},   32'(rb_dirty),   32'(m_dirty[i]));
    check(rb_acc == m_acc[i],      {tag, " accessed"},32'(rb_acc),     32'(m_acc[i]));
    if (cmp_frame)
      check(rb_frame == m_frame[i], {tag, " frame"}, 32'(rb_frame), 32'(m_frame[i]));
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", {6'h0, rsp_trap, rsp_paddr}, 32'h0);
      end else begin
        logic [25:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rsp_trap, rsp_paddr} == e, t, {6'h0, rsp_trap, rsp_paddr}, {6'h0, e});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(rsp_valid == 1'b0, "R10 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    readback(8'h00, 1'b0, "R10 entry 0 after reset");
    readback(8'hFF, 1'b0, "R10 entry FF after reset");
    // R10 limit is zero: page 1 violates, page 0 faults (not present)
    access(16'h0105, 1'b0, "R10 R3 page above reset limit");
    access(16'h0033, 1'b0, "R10 R4 page 0 not present");
    @(negedge clk);
    check(exp_q.size() == 0, "R2 response count", 32'(exp_q.size()), 32'h0);

    set_limit(8'h10);
    twrite(8'h02, 16'h01A0, 1'b1, 1'b0, 1'b0);
    readback(8'h02, 1'b1, "R8 entry 2 after write");
    access(16'h02FE, 1'b0, "R1 read 0x02FE");
    @(negedge clk);
    readback(8'h02, 1'b1, "R5 R6 after read");
    access(16'h0210, 1'b1, "R1 write page 2");
    @(negedge clk);
    readback(8'h02, 1'b1, "R6 after write");
    access(16'h0211, 1'b0, "R1 read page 2 again");
    @(negedge clk);
    readback(8'h02, 1'b1, "R6 dirty stays after read");
    twrite(8'h02, 16'h01A0, 1'b1, 1'b0, 1'b0);
    readback(8'h02, 1'b1, "R6 R8 dirty cleared by table write");

    // Boundary on the limit
    twrite(8'h10, 16'hBEEF, 1'b1, 1'b0, 1'b0);
    twrite(8'h11, 16'hCAFE, 1'b1, 1'b0, 1'b0);
    access(16'h1001, 1'b1, "R3 page equal to limit in range");
    access(16'h1102, 1'b1, "R3 page above limit");
    @(negedge clk);
    readback(8'h11, 1'b1, "R7 status after violation");
    readback(8'h10, 1'b1, "R5 R6 status at limit page");

    // Fault with a backing-store location in the frame field
    twrite(8'h05, 16'h7777, 1'b0, 1'b0, 1'b0);
    access(16'h05AA, 1'b1, "R4 fault hides frame field");
    @(negedge clk);
    readback(8'h05, 1'b1, "R7 status after fault");

    // Streaming pattern across several pages
    for (int k = 0; k < 8; k++)
      twrite(8'(k + 8), 16'(16'h0300 + k * 16'h0111), (k % 3) != 0, 1'b0, 1'b0);
    for (int k = 0; k < 24; k++)
      access({8'(8 + (k % 10)), 8'(k * 37)}, k[0], "R1 R4 streamed access");
    @(negedge clk);
    for (int k = 8; k < 18; k++)
      readback(8'(k), 1'b1, "R5 R6 R7 after stream");

    // Same-cycle table write and access to one entry
    twrite(8'h03, 16'h0AAA, 1'b1, 1'b0, 1'b0);
    set_req(16'h0344, 1'b1, "R9 response uses old contents");
    set_tw(8'h03, 16'h0BBB, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; tw_en = 1'b0;
    readback(8'h03, 1'b1, "R9 written values win");
    access(16'h0345, 1'b0, "R9 next access sees new frame");

    // Same-cycle limit write and access
    set_req(16'h2001, 1'b0, "R9 limit write takes effect later");
    lim_we = 1'b1; lim_val = 8'h40;
    @(negedge clk);
    req_valid = 1'b0; lim_we = 1'b0; m_limit = 8'h40;
    access(16'h2001, 1'b0, "R4 page 0x20 within new limit");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R2 all responses returned", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule